// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block is the command front end of a serial page flash with two SRAM page buffers. It watches the chip-select, serial clock and serial data input of an SPI slave port from inside a faster system clock domain. While chip-select is low it shifts in a 32-bit command frame. The frame is an 8-bit opcode followed by a 24-bit address field. When chip-select goes high it decodes the opcode into an operation kind and a buffer number. It then pulls the page number or the buffer byte offset out of the address field, depending on the kind of operation.

A complete and legal frame launches exactly one start pulse to the downstream sequencer. The decoded fields stay frozen until that sequencer acknowledges. A frame cut short is dropped without any output. A complete frame whose opcode is unknown raises a one-cycle illegal flag instead of a start. Bits that arrive after the 32nd, such as data bytes streamed into a buffer, leave the captured command untouched.

Top module: `sfd_cmd_frontend`

## Requirements
- R1: While `cs_n` is low, `si` is taken on each rising edge of `sck`, most significant bit first. The first 8 bits form the opcode, shown on `cmd_opcode`. The next 24 bits form the address field, numbered 23 (first) down to 0 (last).
- R2: Frames are accepted whether `sck` idles low (mode 0) or idles high (mode 3) while `cs_n` is high. A rising edge of `sck` seen while `cs_n` is high is not counted.
- R3: Opcode decoding, shown as `cmd_kind` / `cmd_buf`:
  - 53h and 55h give kind 0 (page to buffer), buffer 0 and 1.
  - 60h and 61h give kind 1 (compare), buffer 0 and 1.
  - 84h and 87h give kind 2 (buffer write), buffer 0 and 1.
  - 83h and 86h give kind 3 (program with erase), buffer 0 and 1.
  - 88h and 89h give kind 4 (program without erase), buffer 0 and 1.
  - 81h gives kind 5 (page erase), buffer 0.
  - 50h gives kind 6 (block erase), buffer 0.
- R4: For kinds 0, 1, 3, 4 and 5, `cmd_page` equals address bits 22..10. Bit 23 and bits 9..0 are ignored, and `cmd_bufaddr` is 0.
- R5: For kind 2, `cmd_bufaddr` equals address bits 9..0 and `cmd_page` is 0. Bits arriving after the 32nd leave every command output unchanged.
- R6: For kind 6, `cmd_page` equals address bits 22..13 in its upper ten bits, with its low three bits 0. `cmd_bufaddr` is 0.
- R7: A legal, complete frame produces a `start` pulse exactly one clock cycle wide. The pulse comes only after `cs_n` rises, and `busy` goes high together with it.
- R8: If `cs_n` rises after fewer than 32 bits, the frame is discarded: neither `start` nor `illegal` pulses.
- R9: A complete frame with an opcode outside R3 pulses `illegal` for exactly one cycle and produces no `start`.
- R10: While `busy` is high, all `cmd_*` outputs hold their values. An `ack` while busy clears `busy` on the next cycle, and `ack` while idle has no effect.
- R11: A legal frame that completes while `busy` is high is dropped: no `start`, and the held command is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `sck` |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| si | input | 1 | Serial data input |
| ack | input | 1 | Downstream has taken the held command |
| start | output | 1 | One-cycle launch pulse for a decoded command |
| illegal | output | 1 | One-cycle pulse for a complete frame with an unknown opcode |
| busy | output | 1 | A command is held awaiting `ack` |
| cmd_kind | output | 3 | Decoded operation kind (R3 coding) |
| cmd_buf | output | 1 | Buffer number, 0 or 1 |
| cmd_opcode | output | 8 | Raw opcode of the held command |
| cmd_page | output | 13 | Page number (block base for kind 6) |
| cmd_bufaddr | output | 10 | Buffer byte offset for buffer writes |

## Verification
Every one of the 256 opcode values is sent once with an address derived from the opcode. The clock polarity alternates with the opcode's low bit. This separates legal from illegal codes, checks kind and buffer numbering, and shows that both idle polarities frame identically. A single set bit is then walked across all 24 address positions for a page erase, a buffer write and a block erase. This exposes any slip in field position or bit order, and any leak of reserved or don't-care bits into the outputs. Frames of every length from 0 to 31 bits test the discard rule. A buffer write with trailing data, a frame sent while a command is still pending, and an `ack` sent while idle cover the hold-and-release behaviour.

// File: rtl/sfd_pkg.sv
// Shared types for the serial flash command front end.
// Assumes 8-bit opcodes; address layout widths are parameters of the top.
package sfd_pkg;
    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        K_XFER     = 3'd0,
        K_CMP      = 3'd1,
        K_BWR      = 3'd2,
        K_PGM_ERS  = 3'd3,
        K_PGM      = 3'd4,
        K_PERASE   = 3'd5,
        K_BERASE   = 3'd6,
        K_NONE     = 3'd7
    } op_kind_t;

    typedef enum logic [1:0] {
        L_PAGE   = 2'd0,
        L_BUFFER = 2'd1,
        L_BLOCK  = 2'd2
    } addr_layout_t;

    typedef struct packed {
        logic         legal;
        op_kind_t     kind;
        logic         buf_sel;
        addr_layout_t layout;
    } op_info_t;
endpackage

// File: rtl/sfd_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes STAGES >= 2 and that bits of the bundle need not stay coherent.
module sfd_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sfd_shifter.sv
// Frame deserializer: counts serial clock rises while select is low and
// shifts data in MSB first until the frame is full; later bits are ignored.
// Assumes synchronized inputs and at least two system clocks per sck phase.
module sfd_shifter #(
    parameter int OP_W    = 8,
    parameter int ADDR_W  = 24,
    localparam int FRAME_W = OP_W + ADDR_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              si_s,
    output logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-2:0] body,
    output logic              full,
    output logic              cs_rise
);
    logic               sck_q;
    logic               cs_q;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] frame;
    logic               sck_rise;

    assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
    assign cs_rise  = cs_n_s & ~cs_q;
    assign full     = (cnt == CNT_W'(FRAME_W));
    assign opcode   = frame[FRAME_W-1 -: OP_W];
    assign body     = frame[ADDR_W-2:0];

    // Remember the previous level of clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // Count and shift bits of the current frame, clearing on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            frame <= '0;
        end else if (cs_n_s) begin
            cnt <= '0;
        end else if (sck_rise && !full) begin
            frame <= {frame[FRAME_W-2:0], si_s};
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfd_opdecode.sv
// Opcode decoder: maps an 8-bit opcode to operation kind, buffer number and
// address layout. Purely combinational; unknown codes come out not legal.
module sfd_opdecode
    import sfd_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_info_t        info
);
    // Look up the operation described by the opcode.
    always_comb begin
        info = '{legal: 1'b1, kind: K_NONE, buf_sel: 1'b0, layout: L_PAGE};
        case (opcode)
            8'h53: info.kind = K_XFER;
            8'h55: begin info.kind = K_XFER;    info.buf_sel = 1'b1; end
            8'h60: info.kind = K_CMP;
            8'h61: begin info.kind = K_CMP;     info.buf_sel = 1'b1; end
            8'h84: begin info.kind = K_BWR;     info.layout = L_BUFFER; end
            8'h87: begin info.kind = K_BWR;     info.layout = L_BUFFER; info.buf_sel = 1'b1; end
            8'h83: info.kind = K_PGM_ERS;
            8'h86: begin info.kind = K_PGM_ERS; info.buf_sel = 1'b1; end
            8'h88: info.kind = K_PGM;
            8'h89: begin info.kind = K_PGM;     info.buf_sel = 1'b1; end
            8'h81: info.kind = K_PERASE;
            8'h50: begin info.kind = K_BERASE;  info.layout = L_BLOCK; end
            default: info.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfd_addr_extract.sv
// Address field extractor: selects page number or buffer offset from the
// address body (reserved top bit already stripped) according to the layout.
// Assumes the page field sits directly below the reserved bit.
module sfd_addr_extract
    import sfd_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int PAGE_W  = 13,
    parameter int BADDR_W = 10,
    parameter int BLK_LSB = 3,
    localparam int PAGE_LSB = ADDR_W - 1 - PAGE_W,
    localparam int BLK_W    = PAGE_W - BLK_LSB
) (
    input  addr_layout_t       layout,
    input  logic [ADDR_W-2:0]  body,
    output logic [PAGE_W-1:0]  page,
    output logic [BADDR_W-1:0] baddr
);
    // Route the fields that belong to the selected layout, zero the rest.
    always_comb begin
        page  = '0;
        baddr = '0;
        case (layout)
            L_PAGE:   page  = body[PAGE_LSB +: PAGE_W];
            L_BLOCK:  page  = {body[ADDR_W-2 -: BLK_W], {BLK_LSB{1'b0}}};
            L_BUFFER: baddr = body[BADDR_W-1:0];
            default:  page  = '0;
        endcase
    end
endmodule

// File: rtl/sfd_cmd_frontend.sv
// Serial flash command front end: synchronizes the SPI slave pins, collects
// the 32-bit command frame, decodes it on select release and holds the
// result for the downstream sequencer until it acknowledges.
// Assumes clk runs at least four times faster than sck.
module sfd_cmd_frontend
    import sfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 24,
    parameter int PAGE_W      = 13,
    parameter int BADDR_W     = 10,
    parameter int BLK_LSB     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               si,
    input  logic               ack,
    output logic               start,
    output logic               illegal,
    output logic               busy,
    output logic [2:0]         cmd_kind,
    output logic               cmd_buf,
    output logic [OP_W-1:0]    cmd_opcode,
    output logic [PAGE_W-1:0]  cmd_page,
    output logic [BADDR_W-1:0] cmd_bufaddr
);
    logic [2:0]         pins_s;
    logic               cs_n_s, sck_s, si_s;
    logic [OP_W-1:0]    opcode;
    logic [ADDR_W-2:0]  body;
    logic               full, cs_rise;
    op_info_t           info;
    logic [PAGE_W-1:0]  page_d;
    logic [BADDR_W-1:0] baddr_d;
    logic               accept;

    sfd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(pins_s)
    );
    assign {cs_n_s, sck_s, si_s} = pins_s;

    sfd_shifter #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s), .si_s(si_s),
        .opcode(opcode), .body(body), .full(full), .cs_rise(cs_rise)
    );

    sfd_opdecode u_dec (.opcode(opcode), .info(info));

    sfd_addr_extract #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BADDR_W(BADDR_W), .BLK_LSB(BLK_LSB)
    ) u_addr (
        .layout(info.layout), .body(body), .page(page_d), .baddr(baddr_d)
    );

    assign accept = cs_rise && full && info.legal && !busy;

    // Issue pulses, track the pending command and release it on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start   <= 1'b0;
            illegal <= 1'b0;
            busy    <= 1'b0;
        end else begin
            start   <= accept;
            illegal <= cs_rise && full && !info.legal;
            if (accept)          busy <= 1'b1;
            else if (busy && ack) busy <= 1'b0;
        end
    end

    // Capture the decoded command when it is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_kind    <= K_NONE;
            cmd_buf     <= 1'b0;
            cmd_opcode  <= '0;
            cmd_page    <= '0;
            cmd_bufaddr <= '0;
        end else if (accept) begin
            cmd_kind    <= info.kind;
            cmd_buf     <= info.buf_sel;
            cmd_opcode  <= opcode;
            cmd_page    <= page_d;
            cmd_bufaddr <= baddr_d;
        end
    end
endmodule

// File: rtl/sfd_cmd_frontend_chk.sv
// Property checker for the command front end, bound to the top module.
module sfd_cmd_frontend_chk #(
    parameter int PAGE_W  = 13,
    parameter int BADDR_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack,
    input logic               start,
    input logic               illegal,
    input logic               busy,
    input logic [2:0]         cmd_kind,
    input logic               cmd_buf,
    input logic [7:0]         cmd_opcode,
    input logic [PAGE_W-1:0]  cmd_page,
    input logic [BADDR_W-1:0] cmd_bufaddr
);
    // R7
    start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start);
    // R9
    illegal_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);
    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && illegal));
    // R3
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cmd_kind != 3'd7));
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> busy && $stable({cmd_kind, cmd_buf, cmd_opcode, cmd_page, cmd_bufaddr}));
    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack) |=> !busy);
    // R11
    no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !start);
endmodule

bind sfd_cmd_frontend sfd_cmd_frontend_chk #(.PAGE_W(PAGE_W), .BADDR_W(BADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .start(start), .illegal(illegal),
    .busy(busy), .cmd_kind(cmd_kind), .cmd_buf(cmd_buf), .cmd_opcode(cmd_opcode),
    .cmd_page(cmd_page), .cmd_bufaddr(cmd_bufaddr)
);

// File: tb/sfd_cmd_frontend_test.sv
module sfd_cmd_frontend_test;
    localparam int HP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, ack = 1'b0;
    logic start, illegal, busy, cmd_buf;
    logic [2:0]  cmd_kind;
    logic [7:0]  cmd_opcode;
    logic [12:0] cmd_page;
    logic [9:0]  cmd_bufaddr;

    int total = 0, bad = 0, n_start = 0, n_ill = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sfd_cmd_frontend uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .ack(ack),
        .start(start), .illegal(illegal), .busy(busy), .cmd_kind(cmd_kind),
        .cmd_buf(cmd_buf), .cmd_opcode(cmd_opcode), .cmd_page(cmd_page),
        .cmd_bufaddr(cmd_bufaddr)
    );

    always @(negedge clk) if (rst_n) begin
        if (start)   n_start++;
        if (illegal) n_ill++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nbits from the top of bits; mode3 selects idle-high clock.
    task automatic spi_frame(input logic [47:0] bits, input int nbits, input bit mode3);
        sck = mode3; wait_n(2*HP);
        cs_n = 1'b0; wait_n(HP);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0; si = bits[47-i]; wait_n(HP);
            sck = 1'b1; wait_n(HP);
        end
        if (!mode3) sck = 1'b0;
        wait_n(HP);
        cs_n = 1'b1; wait_n(16);
    endtask

    function automatic void exp_dec(input logic [7:0] op, output bit ok, output int kind,
                                    output int bsel, output int lay);
        ok = 1; bsel = 0; lay = 0; kind = 7;
        case (op)
            8'h53: kind = 0;  8'h55: begin kind = 0; bsel = 1; end
            8'h60: kind = 1;  8'h61: begin kind = 1; bsel = 1; end
            8'h84: begin kind = 2; lay = 1; end
            8'h87: begin kind = 2; lay = 1; bsel = 1; end
            8'h83: kind = 3;  8'h86: begin kind = 3; bsel = 1; end
            8'h88: kind = 4;  8'h89: begin kind = 4; bsel = 1; end
            8'h81: kind = 5;
            8'h50: begin kind = 6; lay = 2; end
            default: ok = 0;
        endcase
    endfunction

    task automatic do_ack();
        ack = 1'b1; wait_n(1);
        ack = 1'b0;
        check(busy == 1'b0, "R10 busy after ack", busy, 0);
    endtask

    // Send one frame and check every output against the requirements.
    task automatic run(input logic [7:0] op, input logic [23:0] addr, input bit mode3,
                       input int nbits, input logic [15:0] data);
        bit ok; int kind, bsel, lay, s0, i0, epage, ebaddr;
        s0 = n_start; i0 = n_ill;
        exp_dec(op, ok, kind, bsel, lay);
        epage  = (lay == 0) ? int'(addr[22:10]) : (lay == 2) ? int'({addr[22:13], 3'b000}) : 0;
        ebaddr = (lay == 1) ? int'(addr[9:0]) : 0;
        spi_frame({op, addr, data}, nbits, mode3);
        if (nbits < 32) begin
            check(n_start == s0, "R8 short frame start", n_start - s0, 0);
            check(n_ill == i0, "R8 short frame illegal", n_ill - i0, 0);
        end else if (!ok) begin
            check(n_ill == i0 + 1, "R9 illegal pulses", n_ill - i0, 1);
            check(n_start == s0, "R9 start on unknown", n_start - s0, 0);
        end else begin
            check(n_start == s0 + 1, mode3 ? "R2 start pulses" : "R7 start pulses", n_start - s0, 1);
            check(busy == 1'b1, "R7 busy", busy, 1);
            check(cmd_opcode == op, "R1 opcode", cmd_opcode, op);
            check(int'(cmd_kind) == kind && int'(cmd_buf) == bsel, "R3 kind/buf",
                  {cmd_kind, cmd_buf}, kind * 2 + bsel);
            check(int'(cmd_page) == epage, lay == 2 ? "R6 page" : "R4 page", cmd_page, epage);
            check(int'(cmd_bufaddr) == ebaddr, "R5 bufaddr", cmd_bufaddr, ebaddr);
            wait_n(7);
            check(cmd_page == 13'(epage) && cmd_bufaddr == 10'(ebaddr) && busy,
                  "R10 hold", cmd_page, epage);
            do_ack();
        end
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        check(!start && !illegal && !busy, "R7 reset state", {start, illegal, busy}, 0);
        // R10: ack while idle changes nothing
        ack = 1'b1; wait_n(1); ack = 1'b0; wait_n(1);
        check(!busy && n_start == 0, "R10 idle ack", busy, 0);

        // R3 R9 R2: sweep every opcode, alternating clock polarity
        for (int op = 0; op < 256; op++)
            run(8'(op), {8'(op), ~8'(op), 8'(op) ^ 8'h3c}, op[0], 32, 16'h0);

        // R1 R4 R5 R6: walk a single one through the address field
        for (int b = 0; b < 24; b++) begin
            run(8'h81, 24'(1) << b, b[0], 32, 16'h0);
            run(8'h84, 24'(1) << b, b[1], 32, 16'h0);
            run(8'h50, 24'(1) << b, b[0], 32, 16'h0);
        end

        // R8: every short length
        for (int n = 0; n < 32; n++) run(8'h83, 24'h7fffff, n[0], n, 16'h0);

        // R5: trailing data after the address does not disturb capture
        run(8'h87, 24'h0002a5, 1'b0, 48, 16'hffff);
        run(8'h84, 24'h00015a, 1'b1, 48, 16'h1234);

        // R11: frame while busy is dropped
        begin
            int s0;
            spi_frame({8'h81, 24'h3fffff, 16'h0}, 32, 1'b0);
            check(busy && cmd_page == 13'h0fff, "R11 first held", cmd_page, 13'h0fff);
            s0 = n_start;
            spi_frame({8'h60, 24'h000400, 16'h0}, 32, 1'b1);
            check(n_start == s0, "R11 no second start", n_start - s0, 0);
            check(cmd_page == 13'h0fff && cmd_opcode == 8'h81, "R11 held unchanged", cmd_page, 13'h0fff);
            do_ack();
            run(8'h60, 24'h000400, 1'b1, 32, 16'h0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule